// File: doc/BRIEF.md
# Live Register State Migration Unit

This block moves the contents of a small, clock-enabled register bank into a spare replica bank while the surrounding logic keeps running. The original bank carries on loading its next-state data whenever its per-cell clock enable is high, including during the copy. Each cell has its own transfer path. A 2:1 selector in that path is steered by the live enable. It gives the replica either the value the original currently holds or the same next-state bit the original is about to load. Because of this, the two banks agree from the first capture edge onward. No update can be lost between reading and writing.

A step sequencer runs the copy after a start request. It first turns on the steering path and then forces the replica to load for three clocks. Next it removes the forced load and then the steering. After that it keeps both banks in parallel for one clock before the handover output moves from the original bank to the replica. Once the forced load ends, the replica's load enable follows the functional enable, so both banks track every later update. A parameter selects a level-sensitive storage variant for asynchronous use, in which the enable acts as a transparent gate and data is held when it falls. The default variant uses edge-triggered storage.

Top module: `live_state_migrator`

## Requirements
- R1: A synchronous active-low reset clears both banks and returns the unit to idle: busy, done and use_replica are 0, and hand_q is 0.
- R2: A start sampled while idle or done makes busy high from the next clock for exactly 8 clocks. done then rises as busy falls and stays high until the next start or reset. busy and done are never high together.
- R3: While the replica is being forced to load (busy clocks 2 to 4 after start), each replica cell takes the original's held value when that cell's enable is 0. It takes nxt_d when the enable is 1. At the end of the forced load, rep_q equals orig_q even when the enable stayed 0 throughout.
- R4: Random enable and data activity during a migration does not break coherency. From the first forced load to the end of the migration, rep_q equals orig_q after every clock.
- R5: Before the first migration after reset, rep_q holds 0 whatever ce and nxt_d do.
- R6: After the forced load has ended, each replica cell loads nxt_d exactly when its own ce bit is 1. This continues after done, so rep_q keeps equal to orig_q.
- R7: use_replica is 1 only in the last busy clock and while done is high. hand_q shows orig_q while use_replica is 0 and rep_q while it is 1.
- R8: A start request received while busy is ignored. The migration still finishes at the same clock.
- R9: Each original cell loads its nxt_d bit on a clock where its ce bit is 1 and holds otherwise, independent of the migration.
- R10: In the done state a new start launches another migration. Without a start, done is held indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Circuit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Migration request, sampled on the clock |
| ce | input | NCELLS | Functional clock enable, one bit per cell |
| nxt_d | input | NCELLS | Functional next-state data, one bit per cell |
| orig_q | output | NCELLS | Original bank contents |
| rep_q | output | NCELLS | Replica bank contents |
| hand_q | output | NCELLS | Handover output: original bank, then replica after the switch |
| use_replica | output | 1 | High when hand_q is taken from the replica |
| busy | output | 1 | Migration in progress |
| done | output | 1 | Migration finished, replica in service |

## Verification
The hardest situation to reach is a cell whose enable rises inside the forced-load window. In that case the replica must load the new data on the same edge as the original, not the stale held value. The stimulus drives a different random enable pattern and random data on every clock of many back-to-back migrations. This makes enables rise, fall and stay low across each of the three capture edges, for every cell independently. One migration instead holds every enable low, so the held-value path alone has to carry the state. Further start pulses land inside busy windows and at done, and one reset is applied in the middle of a migration.

// File: rtl/mig_pkg.sv
// Package: shared sequencer state encoding for the live state migrator.
// Assumes: one migration runs at a time; the state order is the step order.
package mig_pkg;
    typedef enum logic [2:0] {
        MS_IDLE     = 3'd0,
        MS_STEER    = 3'd1,
        MS_CAPTURE  = 3'd2,
        MS_UNCAP    = 3'd3,
        MS_UNSTEER  = 3'd4,
        MS_PARALLEL = 3'd5,
        MS_RELEASE  = 3'd6,
        MS_DONE     = 3'd7
    } mig_state_e;
endpackage

// File: rtl/mig_store.sv
// Module: one storage bit with enable. The variant is chosen by parameter:
// an edge-triggered flop (default), or a transparent latch whose gate is the
// enable, holding data when the gate falls. Assumes: reset is active low,
// synchronous in the flop variant and level-acting in the latch variant.
module mig_store #(
    parameter bit USE_LATCH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    generate
        if (USE_LATCH) begin : g_latch
            logic q_l;
            // Transparent while the gate is high, holds on its falling edge.
            always_latch begin
                if (!rst_n)  q_l = 1'b0;
                else if (en) q_l = d;
            end
            assign q = q_l;
        end else begin : g_flop
            logic q_r;
            // Edge-triggered load when enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)  q_r <= 1'b0;
                else if (en) q_r <= d;
            end
            assign q = q_r;
        end
    endgenerate
endmodule

// File: rtl/mig_seq.sv
// Module: migration step sequencer. It steps idle -> steer -> capture (held
// CAP_CYCLES clocks) -> uncapture -> unsteer -> parallel (held PAR_CYCLES
// clocks) -> release -> done. Assumes: start is ignored unless idle or done;
// the tracking flag stays set once the capture window has closed, until reset.
module mig_seq
    import mig_pkg::*;
#(
    parameter int CAP_CYCLES = 3,
    parameter int PAR_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic steer,
    output logic capture,
    output logic track,
    output logic use_rep,
    output logic busy,
    output logic done
);
    localparam int HOLD_MAX = (CAP_CYCLES > PAR_CYCLES) ? CAP_CYCLES : PAR_CYCLES;
    localparam int CW       = $clog2(HOLD_MAX + 1);
    localparam logic [CW-1:0] CAP_LAST = CW'(CAP_CYCLES - 1);
    localparam logic [CW-1:0] PAR_LAST = CW'(PAR_CYCLES - 1);

    mig_state_e    state_q;
    logic [CW-1:0] hold_q;
    logic          track_q;

    // Step register, hold counter and post-capture tracking flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            hold_q  <= '0;
            track_q <= 1'b0;
        end else begin
            case (state_q)
                MS_IDLE, MS_DONE: begin
                    if (start) state_q <= MS_STEER;
                    hold_q <= '0;
                end
                MS_STEER: state_q <= MS_CAPTURE;
                MS_CAPTURE: begin
                    if (hold_q == CAP_LAST) begin
                        state_q <= MS_UNCAP;
                        hold_q  <= '0;
                        track_q <= 1'b1;
                    end else begin
                        hold_q <= hold_q + CW'(1);
                    end
                end
                MS_UNCAP:   state_q <= MS_UNSTEER;
                MS_UNSTEER: state_q <= MS_PARALLEL;
                MS_PARALLEL: begin
                    if (hold_q == PAR_LAST) begin
                        state_q <= MS_RELEASE;
                        hold_q  <= '0;
                    end else begin
                        hold_q <= hold_q + CW'(1);
                    end
                end
                MS_RELEASE: state_q <= MS_DONE;
                default:    state_q <= MS_IDLE;
            endcase
        end
    end

    // Decode the per-step controls from the current step.
    always_comb begin
        steer   = (state_q == MS_STEER) || (state_q == MS_CAPTURE) || (state_q == MS_UNCAP);
        capture = (state_q == MS_CAPTURE);
        use_rep = (state_q == MS_RELEASE) || (state_q == MS_DONE);
        busy    = (state_q != MS_IDLE) && (state_q != MS_DONE);
        done    = (state_q == MS_DONE);
        track   = track_q;
    end
endmodule

// File: rtl/mig_cell.sv
// Module: one cell of the bank: the original bit, its replica bit, and the
// transfer path between them. The live enable picks what the replica is
// offered: the original's held value, or the data the original is loading.
// Assumes: steer, capture and track come from the sequencer.
module mig_cell #(
    parameter bit USE_LATCH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic nd,
    input  logic steer,
    input  logic capture,
    input  logic track,
    output logic orig_q,
    output logic rep_q
);
    logic xfer;
    logic rep_d;
    logic rep_en;

    // Transfer selector and replica input steering.
    always_comb begin
        xfer   = ce ? nd : orig_q;
        rep_d  = steer ? xfer : nd;
        rep_en = capture | (track & ce);
    end

    mig_store #(.USE_LATCH(USE_LATCH)) u_orig (
        .clk(clk), .rst_n(rst_n), .en(ce), .d(nd), .q(orig_q)
    );

    mig_store #(.USE_LATCH(USE_LATCH)) u_rep (
        .clk(clk), .rst_n(rst_n), .en(rep_en), .d(rep_d), .q(rep_q)
    );
endmodule

// File: rtl/live_state_migrator.sv
// Module: top of the live state migrator. It holds NCELLS independent cells,
// one sequencer, and the handover selector. Assumes: ce and nxt_d are
// synchronous to clk, and start is a level sampled on each clock.
module live_state_migrator #(
    parameter int NCELLS     = 4,
    parameter int CAP_CYCLES = 3,
    parameter int PAR_CYCLES = 1,
    parameter bit USE_LATCH  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NCELLS-1:0] ce,
    input  logic [NCELLS-1:0] nxt_d,
    output logic [NCELLS-1:0] orig_q,
    output logic [NCELLS-1:0] rep_q,
    output logic [NCELLS-1:0] hand_q,
    output logic              use_replica,
    output logic              busy,
    output logic              done
);
    logic steer;
    logic capture;
    logic track;

    mig_seq #(.CAP_CYCLES(CAP_CYCLES), .PAR_CYCLES(PAR_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .steer(steer), .capture(capture), .track(track),
        .use_rep(use_replica), .busy(busy), .done(done)
    );

    generate
        for (genvar i = 0; i < NCELLS; i++) begin : g_cell
            mig_cell #(.USE_LATCH(USE_LATCH)) u_cell (
                .clk(clk), .rst_n(rst_n), .ce(ce[i]), .nd(nxt_d[i]),
                .steer(steer), .capture(capture), .track(track),
                .orig_q(orig_q[i]), .rep_q(rep_q[i])
            );
        end
    endgenerate

    // Handover selector: original bank until the switch, then the replica.
    always_comb hand_q = use_replica ? rep_q : orig_q;
endmodule

// File: rtl/mig_chk.sv
// Module: property checker for the live state migrator, bound to the top.
// Assumes: the default edge-triggered storage variant.
module mig_chk #(
    parameter int NCELLS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [NCELLS-1:0] ce,
    input logic [NCELLS-1:0] nxt_d,
    input logic [NCELLS-1:0] orig_q,
    input logic [NCELLS-1:0] rep_q,
    input logic              use_replica,
    input logic              busy,
    input logic              done
);
    // R9: the original bank follows its enables one clock later.
    a_r9_orig_update: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> orig_q == (($past(ce) & $past(nxt_d)) | (~$past(ce) & $past(orig_q))));

    // R2: busy and done never overlap.
    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2: done only ever follows a busy period.
    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R8: once busy, the unit stays busy until it is done.
    a_r8_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R3: the banks agree when a migration finishes.
    a_r3_equal_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rep_q == orig_q);

    // R4 / R6: whenever the replica is in service it matches the original.
    a_r4_equal_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        use_replica |-> rep_q == orig_q);

    // R7: the switch to the replica happens at the end of a busy period.
    a_r7_switch_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_replica) |-> busy);

    // R10: done is left only by a start.
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind live_state_migrator mig_chk #(.NCELLS(NCELLS)) u_mig_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ce(ce), .nxt_d(nxt_d),
    .orig_q(orig_q), .rep_q(rep_q), .use_replica(use_replica),
    .busy(busy), .done(done)
);

// File: tb/tb_live_state_migrator.sv
// Bench: a driver task applies inputs at the falling edge, advances a
// reference model built from the requirements, and queues the expected
// outputs. A monitor pops one item after each rising edge and compares.
module tb_live_state_migrator;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] ce = '0;
    logic [N-1:0] nxt_d = '0;
    logic [N-1:0] orig_q, rep_q, hand_q;
    logic         use_replica, busy, done;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    live_state_migrator #(.NCELLS(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ce(ce), .nxt_d(nxt_d),
        .orig_q(orig_q), .rep_q(rep_q), .hand_q(hand_q),
        .use_replica(use_replica), .busy(busy), .done(done)
    );

    typedef struct {
        logic [N-1:0] orig;
        logic [N-1:0] rep;
        logic [N-1:0] hand;
        logic         busy;
        logic         done;
        logic         usr;
        string        tctl;
        string        trep;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state.
    logic [N-1:0] m_orig = '0;
    logic [N-1:0] m_rep = '0;
    int           m_stage = 0;   // 0 idle, 1..8 busy clock index
    logic         m_done = 1'b0;
    logic         m_track = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [N-1:0] got, input logic [N-1:0] want);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, want);
        end
    endtask

    task automatic drive(input logic rs, input logic st, input logic [N-1:0] c,
                         input logic [N-1:0] d, input string tctl);
        exp_t e;
        logic capnow;
        @(negedge clk);
        rst_n = rs; start = st; ce = c; nxt_d = d;
        if (!rs) begin
            m_orig = '0; m_rep = '0; m_stage = 0; m_done = 1'b0; m_track = 1'b0;
            e.trep = "R1";
            e.tctl = "R1";
        end else begin
            capnow = (m_stage >= 2) && (m_stage <= 4);
            if (capnow)                        e.trep = "R3";
            else if (!m_track)                 e.trep = "R5";
            else if (m_stage >= 5)             e.trep = "R4";
            else                               e.trep = "R6";
            e.tctl = tctl;
            if (capnow)       m_rep = (c & d) | (~c & m_orig);
            else if (m_track) m_rep = (c & d) | (~c & m_rep);
            m_orig = (c & d) | (~c & m_orig);
            if (m_stage == 4) m_track = 1'b1;
            if (m_stage == 0 || m_done) begin
                if (st) begin m_stage = 1; m_done = 1'b0; end
            end else if (m_stage == 8) begin
                m_stage = 0; m_done = 1'b1;
            end else begin
                m_stage++;
            end
        end
        e.orig = m_orig;
        e.rep  = m_rep;
        e.busy = (m_stage >= 1);
        e.done = m_done;
        e.usr  = (m_stage == 8) || m_done;
        e.hand = e.usr ? m_rep : m_orig;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each rising edge, away from the edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk("R9", "orig_q", orig_q, e.orig);
                chk(e.trep, "rep_q", rep_q, e.rep);
                chk("R7", "hand_q", hand_q, e.hand);
                chk("R7", "use_replica", N'(use_replica), N'(e.usr));
                chk(e.tctl, "busy", N'(busy), N'(e.busy));
                chk(e.tctl, "done", N'(done), N'(e.done));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog expired got running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset clears everything.
        repeat (3) drive(1'b0, 1'b0, N'($urandom), N'($urandom), "R1");
        // R5, R9: idle activity never reaches the replica.
        repeat (12) drive(1'b1, 1'b0, N'($urandom), N'($urandom), "R2");
        // R3: migration with every enable held low.
        drive(1'b1, 1'b1, '0, N'($urandom), "R2");
        repeat (10) drive(1'b1, 1'b0, '0, N'($urandom), "R2");
        // R6, R10: replica tracks after done, done holds.
        repeat (15) drive(1'b1, 1'b0, N'($urandom), N'($urandom), "R10");
        // R10 restart from done; R8 starts while busy; R4 random activity.
        drive(1'b1, 1'b1, N'($urandom), N'($urandom), "R10");
        for (int i = 0; i < 10; i++)
            drive(1'b1, (i == 2) || (i == 5), N'($urandom), N'($urandom), "R8");
        // R1: reset in the middle of a migration.
        repeat (4) drive(1'b1, 1'b0, N'($urandom), N'($urandom), "R2");
        drive(1'b1, 1'b1, N'($urandom), N'($urandom), "R2");
        repeat (3) drive(1'b1, 1'b0, N'($urandom), N'($urandom), "R2");
        repeat (2) drive(1'b0, 1'b0, N'($urandom), N'($urandom), "R1");
        repeat (6) drive(1'b1, 1'b0, N'($urandom), N'($urandom), "R2");
        // R4, R8: many migrations under random enables and stray starts.
        for (int k = 0; k < 40; k++) begin
            drive(1'b1, 1'b1, N'($urandom), N'($urandom), "R4");
            for (int j = 0; j < 12; j++)
                drive(1'b1, ($urandom % 4) == 0, N'($urandom), N'($urandom), "R8");
        end
        repeat (3) drive(1'b1, 1'b0, N'($urandom), N'($urandom), "R6");
        @(posedge clk);
        #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule